// File: doc/BRIEF.md
# Stream Traffic Tally Monitor

This block sits beside one streaming interface and watches it without driving it. Each accepted beat adds its valid-byte count to a byte counter. An accepted beat that closes a frame also adds one to a frame counter. The block has no path back into the watched interface, so it can never hold that interface up.

A one-cycle trigger, sent together with a 16-bit tag, does three things in one clock:
- it freezes the current totals;
- it zeroes both counters;
- it starts a ten-byte report frame on a separate byte-wide stream output.

The report frame is ordered as follows:
1. the tag;
2. the byte total;
3. the frame total.

Each field goes out most significant byte first. The block is meant for periodic traffic sampling. A controller pulses the trigger at the end of each measurement window, and a downstream consumer collects the tagged reports.

Top module: `axis_tally_monitor`

## Requirements
- R1: On every clock edge where `mon_tvalid` and `mon_tready` are both high, the byte counter grows by the number of ones in `mon_tkeep` for that beat.
- R2: On every such accepted beat with `mon_tlast` high, the frame counter grows by exactly one.
- R3: A beat with only one of `mon_tvalid` and `mon_tready` high adds nothing to either counter.
- R4: A trigger is taken when `trig` is high while no report is in progress. The totals as they stood before that edge are frozen into the report, and `rpt_tvalid` goes high in the next cycle.
- R5: An accepted beat in the same cycle as a taken trigger counts toward the new window and not toward the frozen report. No transfer is lost or counted twice.
- R6: The report is 10 bytes on `rpt_tdata`, in this order:
  - the tag sampled with the trigger: bits 15:8, then bits 7:0;
  - the 32-bit byte total, most significant byte first;
  - the 32-bit frame total, most significant byte first.
- R7: `rpt_tlast` is high on the tenth report byte only. After that byte is accepted, `rpt_tvalid` is low in the next cycle.
- R8: While `rpt_tvalid` is high and `rpt_tready` is low, `rpt_tdata` and `rpt_tlast` hold their values into the next cycle.
- R9: A trigger that arrives while a report is in progress is ignored. The counters are not cleared, the tag in flight is unchanged, and no second report follows.
- R10: After reset both counters are zero and `rpt_tvalid` is low. The first report taken after reset carries zero totals when no beat has been accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mon_tkeep | input | 8 | Byte-valid lanes of the watched beat |
| mon_tvalid | input | 1 | Watched interface valid |
| mon_tready | input | 1 | Watched interface ready |
| mon_tlast | input | 1 | Watched interface end of frame |
| trig | input | 1 | Capture, clear and report request |
| trig_tag | input | 16 | Tag sampled with a taken trigger |
| rpt_tdata | output | 8 | Report byte |
| rpt_tvalid | output | 1 | Report byte valid |
| rpt_tready | input | 1 | Report consumer ready |
| rpt_tlast | output | 1 | Last report byte |

## Verification
Counting and the capture-and-clear step can land on the same edge.

The bench provokes this by driving an accepted partial beat in the very cycle the trigger is raised. It then checks the following:
- the frozen report excludes that beat;
- the next report carries exactly that beat's bytes and frame.

A second collision is also provoked: a trigger and a complete frame are injected while a report is stalled mid-flight. The bench checks that the frame is kept for the following window and that no extra report appears.

// File: rtl/tally_pkg.sv
package tally_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [0:0] {
        RPT_IDLE = 1'b0,
        RPT_SEND = 1'b1
    } rpt_state_e;

endpackage

// File: rtl/tally_popcount.sv
module tally_popcount #(
    parameter int unsigned KEEP_W = 8,
    parameter int unsigned OUT_W  = 4
) (
    input  logic [KEEP_W-1:0] keep,
    output logic [OUT_W-1:0]  count
);

    // Running prefix sums: part[i] holds the ones among keep[i-1:0].
    logic [OUT_W-1:0] part [KEEP_W+1];

    assign part[0] = '0;

    for (genvar g = 0; g < KEEP_W; g++) begin : g_lane
        assign part[g+1] = part[g] + OUT_W'(keep[g]);
    end

    assign count = part[KEEP_W];

endmodule

// File: rtl/tally_counters.sv
module tally_counters #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned POP_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             beat_fire,
    input  logic             beat_last,
    input  logic [POP_W-1:0] beat_bytes,
    input  logic             clear,
    output logic [CNT_W-1:0] byte_cnt,
    output logic [CNT_W-1:0] frame_cnt
);

    typedef struct packed {
        logic [CNT_W-1:0] bytes;
        logic [CNT_W-1:0] frames;
    } cnt_s;

    cnt_s cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;

        // A clear restarts the window.
        // The beat of the clearing cycle is then added into the fresh window.
        if (clear) begin
            cnt_d.bytes  = '0;
            cnt_d.frames = '0;
        end

        if (beat_fire) begin
            cnt_d.bytes = cnt_d.bytes + CNT_W'(beat_bytes);
            if (beat_last) begin
                cnt_d.frames = cnt_d.frames + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '{bytes: '0, frames: '0};
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign byte_cnt  = cnt_q.bytes;
    assign frame_cnt = cnt_q.frames;

endmodule

// File: rtl/tally_report.sv
module tally_report
    import tally_pkg::*;
#(
    parameter int unsigned TAG_W = 16,
    parameter int unsigned CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [TAG_W-1:0]  tag,
    input  logic [CNT_W-1:0]  byte_snap,
    input  logic [CNT_W-1:0]  frame_snap,
    input  logic              tready,
    output logic [BYTE_W-1:0] tdata,
    output logic              tvalid,
    output logic              tlast,
    output logic              busy
);

    localparam int unsigned TOTAL_W  = TAG_W + 2 * CNT_W;
    localparam int unsigned NBYTES   = TOTAL_W / BYTE_W;
    localparam int unsigned IDX_W    = $clog2(NBYTES + 1);
    localparam int unsigned LAST_IDX = NBYTES - 1;

    typedef struct packed {
        rpt_state_e         st;
        logic [TOTAL_W-1:0] sh;
        logic [IDX_W-1:0]   idx;
    } rpt_s;

    rpt_s rpt_d, rpt_q;
    logic at_end;

    assign at_end = (rpt_q.idx == IDX_W'(LAST_IDX));

    always_comb begin
        rpt_d = rpt_q;
        unique case (rpt_q.st)
            RPT_IDLE: begin
                if (start) begin
                    rpt_d.st  = RPT_SEND;
                    rpt_d.sh  = {tag, byte_snap, frame_snap};
                    rpt_d.idx = '0;
                end
            end
            RPT_SEND: begin
                if (tready) begin
                    if (at_end) begin
                        rpt_d.st  = RPT_IDLE;
                        rpt_d.sh  = '0;
                        rpt_d.idx = '0;
                    end else begin
                        rpt_d.sh  = rpt_q.sh << BYTE_W;
                        rpt_d.idx = rpt_q.idx + IDX_W'(1);
                    end
                end
            end
            default: rpt_d = rpt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rpt_q <= '{st: RPT_IDLE, sh: '0, idx: '0};
        end else begin
            rpt_q <= rpt_d;
        end
    end

    assign tvalid = (rpt_q.st == RPT_SEND);
    assign tdata  = rpt_q.sh[TOTAL_W-1 -: BYTE_W];
    assign tlast  = tvalid && at_end;
    assign busy   = tvalid;

endmodule

// File: rtl/axis_tally_monitor.sv
module axis_tally_monitor
    import tally_pkg::*;
#(
    parameter int unsigned KEEP_W = 8,
    parameter int unsigned TAG_W  = 16,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [KEEP_W-1:0] mon_tkeep,
    input  logic              mon_tvalid,
    input  logic              mon_tready,
    input  logic              mon_tlast,
    input  logic              trig,
    input  logic [TAG_W-1:0]  trig_tag,
    output logic [BYTE_W-1:0] rpt_tdata,
    output logic              rpt_tvalid,
    input  logic              rpt_tready,
    output logic              rpt_tlast
);

    localparam int unsigned POP_W = $clog2(KEEP_W + 1);

    logic             beat_fire;
    logic [POP_W-1:0] beat_bytes;
    logic             rpt_busy;
    logic             take;
    logic [CNT_W-1:0] byte_cnt;
    logic [CNT_W-1:0] frame_cnt;

    assign beat_fire = mon_tvalid && mon_tready;
    assign take      = trig && !rpt_busy;

    tally_popcount #(
        .KEEP_W (KEEP_W),
        .OUT_W  (POP_W)
    ) u_pop (
        .keep  (mon_tkeep),
        .count (beat_bytes)
    );

    tally_counters #(
        .CNT_W (CNT_W),
        .POP_W (POP_W)
    ) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .beat_fire  (beat_fire),
        .beat_last  (mon_tlast),
        .beat_bytes (beat_bytes),
        .clear      (take),
        .byte_cnt   (byte_cnt),
        .frame_cnt  (frame_cnt)
    );

    tally_report #(
        .TAG_W (TAG_W),
        .CNT_W (CNT_W)
    ) u_rpt (
        .clk        (clk),
        .rst        (rst),
        .start      (take),
        .tag        (trig_tag),
        .byte_snap  (byte_cnt),
        .frame_snap (frame_cnt),
        .tready     (rpt_tready),
        .tdata      (rpt_tdata),
        .tvalid     (rpt_tvalid),
        .tlast      (rpt_tlast),
        .busy       (rpt_busy)
    );

endmodule

// File: rtl/tally_checker.sv
module tally_checker #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned POP_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             trig,
    input logic             mon_fire,
    input logic             mon_last,
    input logic [POP_W-1:0] beat_bytes,
    input logic [CNT_W-1:0] byte_cnt,
    input logic [CNT_W-1:0] frame_cnt,
    input logic [7:0]       rpt_tdata,
    input logic             rpt_tvalid,
    input logic             rpt_tready,
    input logic             rpt_tlast
);

    logic taken;
    assign taken = trig && !rpt_tvalid;

    AST_BYTE_ACC: assert property (@(posedge clk) disable iff (rst)
        !taken |=> byte_cnt == $past(byte_cnt) + ($past(mon_fire) ? CNT_W'($past(beat_bytes)) : CNT_W'(0))); // R1

    AST_FRAME_ACC: assert property (@(posedge clk) disable iff (rst)
        !taken |=> frame_cnt == $past(frame_cnt) + CNT_W'($past(mon_fire && mon_last))); // R2

    AST_REPORT_START: assert property (@(posedge clk) disable iff (rst)
        taken |=> rpt_tvalid); // R4

    AST_CLEAR_INTO_NEW: assert property (@(posedge clk) disable iff (rst)
        taken |=> frame_cnt == CNT_W'($past(mon_fire && mon_last))); // R5

    AST_END_DROP: assert property (@(posedge clk) disable iff (rst)
        rpt_tvalid && rpt_tready && rpt_tlast |=> !rpt_tvalid); // R7

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
        rpt_tvalid && !rpt_tready |=> rpt_tvalid && $stable(rpt_tdata) && $stable(rpt_tlast)); // R8

endmodule

bind axis_tally_monitor tally_checker #(
    .CNT_W (CNT_W),
    .POP_W (POP_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .trig       (trig),
    .mon_fire   (beat_fire),
    .mon_last   (mon_tlast),
    .beat_bytes (beat_bytes),
    .byte_cnt   (byte_cnt),
    .frame_cnt  (frame_cnt),
    .rpt_tdata  (rpt_tdata),
    .rpt_tvalid (rpt_tvalid),
    .rpt_tready (rpt_tready),
    .rpt_tlast  (rpt_tlast)
);

// File: tb/tb_axis_tally_monitor.sv
module tb_axis_tally_monitor;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  mon_tkeep = '0;
    logic        mon_tvalid = 1'b0;
    logic        mon_tready = 1'b0;
    logic        mon_tlast = 1'b0;
    logic        trig = 1'b0;
    logic [15:0] trig_tag = '0;
    logic [7:0]  rpt_tdata;
    logic        rpt_tvalid;
    logic        rpt_tready = 1'b0;
    logic        rpt_tlast;

    int total = 0;
    int bad   = 0;
    longint exp_b = 0;
    longint exp_f = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    axis_tally_monitor dut (
        .clk        (clk),
        .rst        (rst),
        .mon_tkeep  (mon_tkeep),
        .mon_tvalid (mon_tvalid),
        .mon_tready (mon_tready),
        .mon_tlast  (mon_tlast),
        .trig       (trig),
        .trig_tag   (trig_tag),
        .rpt_tdata  (rpt_tdata),
        .rpt_tvalid (rpt_tvalid),
        .rpt_tready (rpt_tready),
        .rpt_tlast  (rpt_tlast)
    );

    task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_beat(input logic [7:0] k, input logic l, input logic v, input logic r);
        mon_tkeep  = k;
        mon_tlast  = l;
        mon_tvalid = v;
        mon_tready = r;
        if (v && r) begin
            exp_b += $countones(k);
            exp_f += l;
        end
    endtask

    task automatic idle_mon();
        mon_tkeep  = '0;
        mon_tlast  = 1'b0;
        mon_tvalid = 1'b0;
        mon_tready = 1'b0;
    endtask

    task automatic beat(input logic [7:0] k, input logic l, input logic v, input logic r);
        drive_beat(k, l, v, r);
        @(negedge clk);
        idle_mon();
    endtask

    // Raise trig for one cycle, optionally together with an accepted beat.
    task automatic trigger(input logic [15:0] tag, input bit with_beat, input logic [7:0] k,
                           input logic l, output logic [79:0] snap);
        snap  = {tag, exp_b[31:0], exp_f[31:0]};
        exp_b = 0;
        exp_f = 0;
        trig     = 1'b1;
        trig_tag = tag;
        if (with_beat) drive_beat(k, l, 1'b1, 1'b1);
        @(negedge clk);
        trig = 1'b0;
        idle_mon();
    endtask

    // Collect one report; stall inserts backpressure, inj raises an extra trigger and beat mid-report.
    task automatic read_report(input bit stall, input bit inj, output logic [79:0] val,
                               output bit last_ok, output bit hold_ok, output int got);
        int guard = 0;
        bit was_stalled = 1'b0;
        logic [7:0] hd = '0;
        logic hl = 1'b0;
        val = '0;
        last_ok = 1'b1;
        hold_ok = 1'b1;
        got = 0;
        while (got < 10 && guard < 200) begin
            guard++;
            if (was_stalled && (rpt_tdata !== hd || rpt_tlast !== hl || rpt_tvalid !== 1'b1))
                hold_ok = 1'b0;
            rpt_tready = stall ? ((guard % 3) == 0) : 1'b1;
            if (inj && guard == 4) begin
                trig     = 1'b1;
                trig_tag = 16'hDEAD;
                drive_beat(8'hFF, 1'b1, 1'b1, 1'b1);
            end
            was_stalled = 1'b0;
            if (rpt_tvalid && rpt_tready) begin
                val = {val[71:0], rpt_tdata};
                if (rpt_tlast !== (got == 9)) last_ok = 1'b0;
                got++;
            end else if (rpt_tvalid) begin
                was_stalled = 1'b1;
                hd = rpt_tdata;
                hl = rpt_tlast;
            end
            @(negedge clk);
            trig = 1'b0;
            idle_mon();
        end
        rpt_tready = 1'b0;
    endtask

    task automatic check_report(input string tname, input logic [79:0] act, input logic [79:0] exp,
                                input bit last_ok, input int got);
        chk(got == 10, {"R6 ", tname, " byte count"}, 80'(got), 80'd10);
        chk(act[79:64] === exp[79:64], {"R6 ", tname, " tag"}, 80'(act[79:64]), 80'(exp[79:64]));
        chk(act[63:32] === exp[63:32], {"R1 ", tname, " byte total"}, 80'(act[63:32]), 80'(exp[63:32]));
        chk(act[31:0] === exp[31:0], {"R2 ", tname, " frame total"}, 80'(act[31:0]), 80'(exp[31:0]));
        chk(last_ok, {"R7 ", tname, " tlast placement"}, 80'(last_ok), 80'd1);
        chk(rpt_tvalid === 1'b0, {"R7 ", tname, " valid drops after end"}, 80'(rpt_tvalid), 80'd0);
    endtask

    task automatic t_reset();
        logic [79:0] snap, v;
        bit lo, ho;
        int g;
        chk(rpt_tvalid === 1'b0, "R10 valid low after reset", 80'(rpt_tvalid), 80'd0);
        chk(rpt_tlast === 1'b0, "R10 last low after reset", 80'(rpt_tlast), 80'd0);
        trigger(16'h1111, 1'b0, 8'h00, 1'b0, snap);
        chk(rpt_tvalid === 1'b1, "R4 valid one cycle after trigger", 80'(rpt_tvalid), 80'd1);
        read_report(1'b0, 1'b0, v, lo, ho, g);
        check_report("reset", v, snap, lo, g);
        chk(v[63:0] === 64'd0, "R10 zero totals after reset", 80'(v[63:0]), 80'd0);
    endtask

    task automatic t_basic();
        logic [79:0] snap, v;
        bit lo, ho;
        int g;
        beat(8'hFF, 1'b0, 1'b1, 1'b1);
        beat(8'hFF, 1'b1, 1'b1, 1'b1);
        beat(8'h0F, 1'b0, 1'b1, 1'b1);
        beat(8'hF0, 1'b1, 1'b1, 1'b1);
        beat(8'h01, 1'b1, 1'b1, 1'b1);
        beat(8'hA5, 1'b0, 1'b1, 1'b1);
        trigger(16'hBEEF, 1'b0, 8'h00, 1'b0, snap);
        read_report(1'b0, 1'b0, v, lo, ho, g);
        check_report("basic", v, snap, lo, g);
        chk(v === {16'hBEEF, 32'd29, 32'd3}, "R1 R2 basic literal", v, {16'hBEEF, 32'd29, 32'd3});
    endtask

    task automatic t_no_handshake();
        logic [79:0] snap, v;
        bit lo, ho;
        int g;
        beat(8'hFF, 1'b1, 1'b1, 1'b0);
        beat(8'hFF, 1'b1, 1'b0, 1'b1);
        beat(8'h03, 1'b0, 1'b1, 1'b1);
        trigger(16'h0102, 1'b0, 8'h00, 1'b0, snap);
        read_report(1'b0, 1'b0, v, lo, ho, g);
        chk(v[63:0] === {32'd2, 32'd0}, "R3 half handshakes ignored", 80'(v[63:0]), 80'({32'd2, 32'd0}));
    endtask

    task automatic t_same_cycle();
        logic [79:0] snap, v;
        bit lo, ho;
        int g;
        beat(8'h07, 1'b0, 1'b1, 1'b1);
        trigger(16'h5A5A, 1'b1, 8'h0F, 1'b1, snap);
        read_report(1'b0, 1'b0, v, lo, ho, g);
        chk(v === {16'h5A5A, 32'd3, 32'd0}, "R5 report excludes trigger-cycle beat", v, {16'h5A5A, 32'd3, 32'd0});
        trigger(16'h5A5B, 1'b0, 8'h00, 1'b0, snap);
        read_report(1'b0, 1'b0, v, lo, ho, g);
        chk(v === {16'h5A5B, 32'd4, 32'd1}, "R5 next report holds trigger-cycle beat", v, {16'h5A5B, 32'd4, 32'd1});
    endtask

    task automatic t_stall_ignore();
        logic [79:0] snap, v;
        bit lo, ho;
        int g;
        beat(8'h3C, 1'b1, 1'b1, 1'b1);
        trigger(16'hC0DE, 1'b0, 8'h00, 1'b0, snap);
        read_report(1'b1, 1'b1, v, lo, ho, g);
        check_report("stalled", v, snap, lo, g);
        chk(ho, "R8 data held while stalled", 80'(ho), 80'd1);
        chk(v[79:64] === 16'hC0DE, "R9 tag unchanged by mid-report trigger", 80'(v[79:64]), 80'hC0DE);
        @(negedge clk);
        chk(rpt_tvalid === 1'b0, "R9 no second report", 80'(rpt_tvalid), 80'd0);
        trigger(16'h2222, 1'b0, 8'h00, 1'b0, snap);
        read_report(1'b0, 1'b0, v, lo, ho, g);
        chk(v === {16'h2222, 32'd8, 32'd1}, "R9 counters kept across ignored trigger", v, {16'h2222, 32'd8, 32'd1});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_no_handshake();
        t_same_cycle();
        t_stall_ignore();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule